// File: doc/BRIEF.md
# Dual-Style Host Bus Slave Interface

This block is the slave port between an external microprocessor bus and two internal targets: a small register file and a 16-bit buffer RAM port. It accepts either of two strobe conventions, selected by a style input. One uses separate active-low read and write strobes. The other uses a direction line together with an active-low data strobe. Addressing is also either non-multiplexed, with three address pins, or multiplexed. In multiplexed mode the address travels on the low data lines and is captured by an address latch enable.

Bus strobes are synchronized to the internal clock. A write becomes a single-cycle internal write pulse once the strobe is released. Reads are answered combinationally, with separate drive enables for the low and high byte lanes. A local configuration register sits at its own address. It enables the 16-bit data path, selects byte swapping between the bus and the RAM port, and sets the active polarity of the DMA request output and the terminal-count input. The block also decodes a DMA acknowledge and turns the falling edge of a refresh-execution input into a one-cycle pulse.

Top module: `host_bus_if`

## Requirements
- R1: With non-multiplexed addressing, `rd_sel` equals `addr_pin` (bit 0 least significant), and a write captures that address on `wr_sel`.
- R2: Addressing mode is strapped while `rst_n` is low: `addr_pin[0]` low selects multiplexed mode. In that mode, `d_in[2:0]` is captured into the address on every clock while `addr_pin[2]` (the latch enable) is high. `d_in[7:3]` never reach the address.
- R3: Separate-strobe style (`ds_style`=0): `wr_dir` low with `cs_n` low is a write, and `rd_ds` low with `cs_n` low is a read that raises `lo_oe`. A write to any address other than the data (4) and configuration (7) addresses produces `reg_wr` with `reg_wdata` = `d_in[7:0]`.
- R4: Direction/strobe style (`ds_style`=1): with `rd_ds` low, `wr_dir` low means write and `wr_dir` high means read.
- R5: While `cs_n` is high, no strobe produces `lo_oe`, `hi_oe`, `reg_wr` or `ram_wr`.
- R6: Each write gives exactly one single-cycle pulse. The pulse comes 3 clocks after strobe release with `timing_sel` high, and 2 clocks after with `timing_sel` low. The fast setting is ignored in multiplexed mode, which keeps 3 clocks.
- R7: `hi_oe` is high only during a read of the data address with the 16-bit enable set (configuration bit 0). With the enable clear, the data read returns `{8'h00, ram_rdata[7:0]}` and a data write gives `ram_wdata` = `{8'h00, d_in[7:0]}`. With the enable set, all 16 bits pass.
- R8: `io16_n` is low exactly while `cs_n` is low, the current address is the data address, and the 16-bit enable is set.
- R9: Configuration bit 1 swaps the two bytes of a 16-bit word between bus and RAM port, in both read and write directions.
- R10: `dreq` = `dma_req`, inverted when configuration bit 2 is set. `tc_hit` = `tc`, inverted when configuration bit 3 is set. `dma_ack` = NOT `dack_n`.
- R11: A falling edge on `refex_n` yields a one-cycle `ref_pulse` 2 clocks later. A rising edge yields none.
- R12: Reset clears the configuration register (reads 0 at address 7), the latched address and the sync state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset; mode strap sampled meanwhile |
| cs_n | input | 1 | Chip select, active low |
| ds_style | input | 1 | 0: separate strobes, 1: direction plus data strobe |
| timing_sel | input | 1 | 0: fast timing (non-multiplexed only), 1: normal |
| addr_pin | input | 3 | Address pins; bit 0 mode strap, bit 2 latch enable when multiplexed |
| wr_dir | input | 1 | Write strobe or direction (low = write) |
| rd_ds | input | 1 | Read strobe or data strobe, active low |
| d_in | input | 16 | Bus data in |
| d_out | output | 16 | Bus data out |
| lo_oe | output | 1 | Drive enable, low byte lane |
| hi_oe | output | 1 | Drive enable, high byte lane |
| io16_n | output | 1 | 16-bit access indicator, active low |
| rd_sel | output | 3 | Current register select for reads |
| reg_rdata | input | 8 | Register file read data |
| wr_sel | output | 3 | Register select for the write pulse |
| reg_wr | output | 1 | Register file write pulse |
| reg_wdata | output | 8 | Register file write data |
| ram_rdata | input | 16 | Buffer RAM read data |
| ram_wr | output | 1 | Buffer RAM write pulse |
| ram_wdata | output | 16 | Buffer RAM write data |
| ram_wide | output | 1 | 16-bit path enabled |
| dma_req | input | 1 | Internal DMA request, active high |
| dreq | output | 1 | DMA request at selected polarity |
| tc | input | 1 | Terminal count pin |
| tc_hit | output | 1 | Terminal count, active high internally |
| dack_n | input | 1 | DMA acknowledge, active low |
| dma_ack | output | 1 | DMA acknowledge, active high |
| refex_n | input | 1 | Refresh-execution input |
| ref_pulse | output | 1 | One-cycle refresh pulse |

## Verification
The bench builds the block with its default parameters: data register at select 4 and configuration register at select 7. Under that layout the configuration register is reachable from both addressing modes, so every polarity, swap and width option can be set over the bus. The remaining selects 0 to 3, 5 and 6 fall through to the register file, which lets one vector table cover the decode in both strobe styles. Re-strapping the mode through a second reset brings the latch-enable path and the ignored fast-timing request within reach.

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter logic [2:0] DATA_SEL = 3'd4,
  parameter logic [2:0] CFG_SEL  = 3'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ds_style,
  input  logic        timing_sel,
  input  logic [2:0]  addr_pin,
  input  logic        wr_dir,
  input  logic        rd_ds,
  input  logic [15:0] d_in,
  output logic [15:0] d_out,
  output logic        lo_oe,
  output logic        hi_oe,
  output logic        io16_n,
  output logic [2:0]  rd_sel,
  input  logic [7:0]  reg_rdata,
  output logic [2:0]  wr_sel,
  output logic        reg_wr,
  output logic [7:0]  reg_wdata,
  input  logic [15:0] ram_rdata,
  output logic        ram_wr,
  output logic [15:0] ram_wdata,
  output logic        ram_wide,
  input  logic        dma_req,
  output logic        dreq,
  input  logic        tc,
  output logic        tc_hit,
  input  logic        dack_n,
  output logic        dma_ack,
  input  logic        refex_n,
  output logic        ref_pulse
);

  logic        mux_mode, wide_en, swap_en, dreq_lo, tc_lo;
  logic [2:0]  ale_addr, hold_addr;
  logic [15:0] hold_d;
  logic [3:0]  wsync;
  logic [2:0]  rsync;

  wire sel     = ~cs_n;
  wire ale     = addr_pin[2];
  wire wr_act  = sel & ~wr_dir & (ds_style ? ~rd_ds : 1'b1);
  wire rd_act  = sel & ~rd_ds & (ds_style ? wr_dir : 1'b1);
  wire fast    = ~timing_sel & ~mux_mode;
  wire wpulse  = fast ? (wsync[2] & ~wsync[1]) : (wsync[3] & ~wsync[2]);

  assign rd_sel  = mux_mode ? ale_addr : addr_pin;
  wire   at_data = (rd_sel == DATA_SEL);
  wire   at_cfg  = (rd_sel == CFG_SEL);

  assign lo_oe    = rd_act;
  assign hi_oe    = rd_act & at_data & wide_en;
  assign io16_n   = ~(sel & at_data & wide_en);
  assign ram_wide = wide_en;

  always_comb begin
    if (at_cfg)
      d_out = {12'h000, tc_lo, dreq_lo, swap_en, wide_en};
    else if (at_data)
      d_out = !wide_en ? {8'h00, ram_rdata[7:0]} :
              swap_en  ? {ram_rdata[7:0], ram_rdata[15:8]} : ram_rdata;
    else
      d_out = {8'h00, reg_rdata};
  end

  assign wr_sel    = hold_addr;
  assign reg_wdata = hold_d[7:0];
  assign reg_wr    = wpulse & (hold_addr != DATA_SEL) & (hold_addr != CFG_SEL);
  assign ram_wr    = wpulse & (hold_addr == DATA_SEL);
  assign ram_wdata = !wide_en ? {8'h00, hold_d[7:0]} :
                     swap_en  ? {hold_d[7:0], hold_d[15:8]} : hold_d;

  assign dreq      = dma_req ^ dreq_lo;
  assign tc_hit    = tc ^ tc_lo;
  assign dma_ack   = ~dack_n;
  assign ref_pulse = rsync[2] & ~rsync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_mode  <= ~addr_pin[0];
      ale_addr  <= '0;
      hold_addr <= '0;
      hold_d    <= '0;
      wsync     <= '0;
      rsync     <= '1;
      wide_en   <= 1'b0;
      swap_en   <= 1'b0;
      dreq_lo   <= 1'b0;
      tc_lo     <= 1'b0;
    end else begin
      wsync <= {wsync[2:0], wr_act};
      rsync <= {rsync[1:0], refex_n};
      if (mux_mode && ale) ale_addr <= d_in[2:0];
      if (wr_act) begin
        hold_addr <= rd_sel;
        hold_d    <= d_in;
      end
      if (wpulse && hold_addr == CFG_SEL)
        {tc_lo, dreq_lo, swap_en, wide_en} <= hold_d[3:0];
    end
  end

endmodule

module host_bus_if_chk (
  input logic clk,
  input logic rst_n,
  input logic lo_oe,
  input logic hi_oe,
  input logic io16_n,
  input logic reg_wr,
  input logic ram_wr,
  input logic ref_pulse,
  input logic refex_n
);

  p_hi_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe |-> (lo_oe && !io16_n));

  p_reg_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_ram_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> !ram_wr);

  p_ref_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  p_ref_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> !$past(refex_n, 2));

endmodule

bind host_bus_if host_bus_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lo_oe(lo_oe), .hi_oe(hi_oe), .io16_n(io16_n),
  .reg_wr(reg_wr), .ram_wr(ram_wr), .ref_pulse(ref_pulse), .refex_n(refex_n)
);

// File: tb/host_bus_if_tb_top.sv
module host_bus_if_tb_top;
  logic clk = 0, rst_n = 0, cs_n = 1, ds_style = 0, timing_sel = 1;
  logic [2:0] addr_pin = 3'b001;
  logic wr_dir = 1, rd_ds = 1;
  logic [15:0] d_in = 0, d_out, ram_wdata;
  logic lo_oe, hi_oe, io16_n, reg_wr, ram_wr, ram_wide, dreq, tc_hit, dma_ack, ref_pulse;
  logic [2:0] rd_sel, wr_sel;
  logic [7:0] reg_rdata, reg_wdata;
  logic [15:0] ram_rdata = 16'hC41E;
  logic dma_req = 1, tc = 0, dack_n = 1, refex_n = 1;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign reg_rdata = {5'b10100, rd_sel};

  host_bus_if dut_i (.*);

  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'h3C}, {3'd1, 8'h81}, {3'd2, 8'h5A},
    {3'd3, 8'hF0}, {3'd5, 8'h0F}, {3'd6, 8'hC3}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int lat; logic isreg; logic [2:0] ws; logic [7:0] wd; logic [15:0] rwd;
  logic [15:0] rv; logic rlo, rhi, rio;

  task automatic bus_write(input logic [2:0] pins, input logic [15:0] data);
    @(negedge clk);
    addr_pin = pins; d_in = data; cs_n = 0; wr_dir = 0;
    if (ds_style) rd_ds = 0;
    repeat (5) @(negedge clk);
    rd_ds = 1; wr_dir = 1;
    lat = 0; isreg = 0; ws = 0; wd = 0; rwd = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (lat == 0 && (reg_wr || ram_wr)) begin
        lat = k; isreg = reg_wr; ws = wr_sel; wd = reg_wdata; rwd = ram_wdata;
      end
    end
    cs_n = 1;
  endtask

  task automatic bus_read(input logic [2:0] pins);
    @(negedge clk);
    addr_pin = pins; cs_n = 0; rd_ds = 0; wr_dir = 1;
    #2;
    rv = d_out; rlo = lo_oe; rhi = hi_oe; rio = io16_n;
    @(negedge clk);
    rd_ds = 1; cs_n = 1;
  endtask

  task automatic do_reset(input logic a0);
    @(negedge clk);
    rst_n = 0; addr_pin = {2'b00, a0};
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    #1;
    chk("R12 lo_oe idle", lo_oe, 0);
    chk("R12 hi_oe idle", hi_oe, 0);
    chk("R12 io16_n idle", io16_n, 1);
    chk("R12 dreq default polarity", dreq, 1);
    chk("R11 no refresh pulse idle", ref_pulse, 0);
    bus_read(3'd7);
    chk("R12 cfg reads zero", rv, 16'h0000);

    for (int i = 0; i < 6; i++) begin
      ds_style = i[0];
      bus_write(VEC[i][10:8], {8'hEE, VEC[i][7:0]});
      chk(ds_style ? "R4 write is reg" : "R3 write is reg", isreg, 1);
      chk("R1 wr_sel", ws, VEC[i][10:8]);
      chk("R3 reg_wdata", wd, VEC[i][7:0]);
      chk("R6 normal latency", lat, 3);
      bus_read(VEC[i][10:8]);
      chk(ds_style ? "R4 read lo_oe" : "R3 read lo_oe", rlo, 1);
      chk("R1 read data", rv, {8'h00, 5'b10100, VEC[i][10:8]});
    end
    ds_style = 0;

    // R5: strobes with chip select high
    @(negedge clk);
    addr_pin = 3'd2; cs_n = 1; rd_ds = 0; #2;
    chk("R5 no lo_oe deselected", lo_oe, 0);
    rd_ds = 1; wr_dir = 0;
    repeat (5) @(negedge clk);
    wr_dir = 1; lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (reg_wr || ram_wr) lat = k;
    end
    chk("R5 no write deselected", lat, 0);

    timing_sel = 0;
    bus_write(3'd1, 16'h0042);
    chk("R6 fast latency", lat, 2);
    timing_sel = 1;

    bus_write(3'd4, 16'hAB77);
    chk("R7 narrow ram write fires", ram_wr === 0 && lat == 3, 1);
    chk("R7 narrow ram_wdata", rwd, 16'h0077);
    bus_read(3'd4);
    chk("R7 narrow hi_oe", rhi, 0);
    chk("R8 narrow io16_n", rio, 1);
    chk("R7 narrow read data", rv, 16'h001E);

    bus_write(3'd7, 16'h0001);
    bus_read(3'd7);
    chk("R7 cfg wide readback", rv, 16'h0001);
    bus_read(3'd4);
    chk("R7 wide hi_oe", rhi, 1);
    chk("R8 wide io16_n", rio, 0);
    chk("R7 wide read data", rv, 16'hC41E);
    bus_read(3'd3);
    chk("R8 io16_n other reg", rio, 1);
    chk("R7 hi_oe other reg", rhi, 0);
    @(negedge clk); addr_pin = 3'd4; cs_n = 0; #2;
    chk("R8 io16_n addressed no strobe", io16_n, 0);
    chk("R7 hi_oe no strobe", hi_oe, 0);
    cs_n = 1; #1;
    chk("R8 io16_n deselected", io16_n, 1);
    bus_write(3'd4, 16'hBEEF);
    chk("R7 wide ram_wdata", rwd, 16'hBEEF);

    bus_write(3'd7, 16'h0003);
    bus_read(3'd4);
    chk("R9 swapped read", rv, 16'h1EC4);
    bus_write(3'd4, 16'h1234);
    chk("R9 swapped write", rwd, 16'h3412);

    @(negedge clk); dma_req = 1; tc = 1; dack_n = 0; #1;
    chk("R10 dreq high polarity", dreq, 1);
    chk("R10 tc high polarity", tc_hit, 1);
    chk("R10 dma_ack", dma_ack, 1);
    bus_write(3'd7, 16'h000C);
    #1;
    chk("R10 dreq low polarity", dreq, 0);
    chk("R10 tc low polarity", tc_hit, 0);
    dack_n = 1; #1;
    chk("R10 dma_ack idle", dma_ack, 0);

    @(negedge clk); refex_n = 0; lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (ref_pulse && lat == 0) lat = k;
    end
    chk("R11 fall pulse delay", lat, 2);
    refex_n = 1; lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (ref_pulse) lat = k;
    end
    chk("R11 no pulse on rise", lat, 0);

    // multiplexed mode via strap
    do_reset(1'b0);
    #1;
    chk("R12 dreq polarity restored", dreq, 1);
    @(negedge clk); addr_pin = 3'b100; d_in = 16'h00F9;
    @(negedge clk); addr_pin = 3'b000; d_in = 16'h0000; #1;
    chk("R2 latched address ignores d3-d7", rd_sel, 3'd1);
    @(negedge clk); addr_pin = 3'b011; #1;
    chk("R2 pins ignored when multiplexed", rd_sel, 3'd1);
    timing_sel = 0;
    bus_write(3'b000, 16'h0066);
    chk("R2 mux write target", ws, 3'd1);
    chk("R2 mux write data", wd, 8'h66);
    chk("R6 fast ignored in mux", lat, 3);
    timing_sel = 1;
    bus_read(3'b000);
    chk("R2 mux read data", rv, 16'h00A1);
    @(negedge clk); addr_pin = 3'b100; d_in = 16'h0007;
    @(negedge clk); addr_pin = 3'b000; d_in = 16'h0000;
    bus_read(3'b000);
    chk("R12 cfg zero after reset", rv, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule